// File: doc/BRIEF.md
# Programmable Display Raster Timing Generator

This block drives the horizontal sync, vertical sync and data-enable lines of a parallel RGB panel, together with the pixel color bus. Every timing value comes from a small register file that is written through a simple write-only register port. Horizontal events are counted in pixel clocks within a line. Vertical events are compared against a single counter that runs across the whole frame in pixel clocks, not in lines. Because of this, the vertical display window can begin and end at any pixel clock, which gives a sub-line skew relative to hsync. To use that skew, software adds it to the vertical start and end values.

An optional inset active window can be placed inside the display area. Display pixels outside that window are filled with a programmable border color. Inside the window the block raises a pixel-request strobe. When the pixel source does not grant a request, the block drives an underflow color and sets a sticky underflow state. The recovery bit decides when that state clears: either at the next frame start, or only when the block is disabled. The block emits a one-cycle frame-start interrupt each time the frame counter returns to zero. All register writes except the control register are staged and take effect at a frame boundary.

Top module: `raster_timing_gen`

## Requirements
- R1: Writing 1 to bit 0 of register 0 starts generation one clock after the write is captured, and the frame counter starts at zero. Writing 0 stops generation. While stopped, pix_req and frame_irq are 0, rgb is 0, and each sync or enable output sits at its inactive level.
- R2: Register 1 holds the line period in bits 31:16 and the hsync width in bits 15:0. Before polarity is applied, hsync is high for the first width clocks of every line of that period.
- R3: Register 4 holds the vsync width in pixel clocks, and register 3 holds the frame period in pixel clocks. Before polarity is applied, vsync is high while the frame pixel count is below the vsync width.
- R4: Register 2 holds the horizontal display end in bits 31:16 and the start in bits 15:0, both inclusive. Registers 5 and 6 hold the vertical display start and end in frame pixel clocks, both inclusive. Before polarity is applied, de is high exactly when both counts lie inside these windows.
- R5: Registers 7 and 8 give the active-window x start and x end, with the enable in register 7 bit 31. Registers 9 and 10 give the y start and y end in frame pixel clocks, with the enable in register 9 bit 31. A cleared enable makes that axis follow the display window. Display pixels outside the active window drive the border color from register 12 bits 23:0, with de high and no request.
- R6: Inside the active window the block raises pix_req. When pix_gnt is high in the same cycle, rgb equals pix_data.
- R7: A request that is not granted drives the underflow color from register 13 bits 23:0 in that cycle and sets an underflow state. While that state is set, active pixels drive the underflow color and pix_req stays low.
- R8: When register 13 bit 31 is set, the underflow state clears at the next frame start. When it is clear, the state persists until the block is stopped and started again.
- R9: In register 11, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R10: Writes to registers 1 to 13 take effect only at the start of the next frame, or when generation starts.
- R11: frame_irq is high for exactly the one cycle in which the frame pixel count is zero while running.
- R12: Outside the display window, rgb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| pix_gnt | input | 1 | Pixel source supplies data this cycle |
| pix_data | input | 24 | Pixel color from the source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | 24 | Pixel color to the panel |
| pix_req | output | 1 | Pixel request strobe |
| frame_irq | output | 1 | Frame-start pulse |

## Verification
Some behaviours are checked by assertions on every cycle:
- a request is only raised inside the display window;
- blank pixels are zero;
- an ungranted request shows the underflow color;
- the sticky state holds within a frame when recovery is off;
- the frame pulse lasts a single cycle;
- a stopped block stays quiet.

Other behaviours can only be shown by the bench's scenarios, which run the behavioural model alongside the design: the exact line and frame positions of the sync and window edges, the placement of the inset window, the deferral of mid-frame writes to the next frame, and the two recovery policies across frame boundaries and a restart.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 16,
  parameter int FW = 24,
  parameter int CW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          pix_gnt,
  input  logic [CW-1:0] pix_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] rgb,
  output logic          pix_req,
  output logic          frame_irq
);
  localparam int NREG = 14;

  logic [31:0]   live [1:NREG-1];
  logic [31:0]   sh   [1:NREG-1];
  logic          ctrl_en, run, uf;
  logic [HW-1:0] hc;
  logic [FW-1:0] fc;

  logic [HW-1:0] hper, hpw, hds, hde, ahs, ahe;
  logic [FW-1:0] vper, vpw, vds, vde, avs, ave;
  logic          ah_en, av_en, rec;
  logic [2:0]    pol;
  logic [CW-1:0] bord, ufc;

  assign hper  = sh[1][16 +: HW];
  assign hpw   = sh[1][HW-1:0];
  assign hde   = sh[2][16 +: HW];
  assign hds   = sh[2][HW-1:0];
  assign vper  = sh[3][FW-1:0];
  assign vpw   = sh[4][FW-1:0];
  assign vds   = sh[5][FW-1:0];
  assign vde   = sh[6][FW-1:0];
  assign ahs   = sh[7][HW-1:0];
  assign ah_en = sh[7][31];
  assign ahe   = sh[8][HW-1:0];
  assign avs   = sh[9][FW-1:0];
  assign av_en = sh[9][31];
  assign ave   = sh[10][FW-1:0];
  assign pol   = sh[11][2:0];
  assign bord  = sh[12][CW-1:0];
  assign ufc   = sh[13][CW-1:0];
  assign rec   = sh[13][31];

  logic hwrap, fwrap;
  assign hwrap = ({1'b0, hc} + 1'b1) >= {1'b0, hper};
  assign fwrap = ({1'b0, fc} + 1'b1) >= {1'b0, vper};

  logic hs_raw, vs_raw, disp, hact, vact, act;
  assign hs_raw = run && (hc < hpw);
  assign vs_raw = run && (fc < vpw);
  assign disp   = run && (hc >= hds) && (hc <= hde) && (fc >= vds) && (fc <= vde);
  assign hact   = ah_en ? ((hc >= ahs) && (hc <= ahe)) : 1'b1;
  assign vact   = av_en ? ((fc >= avs) && (fc <= ave)) : 1'b1;
  assign act    = disp && hact && vact;

  assign pix_req   = act && !uf;
  assign frame_irq = run && (fc == '0);
  assign hsync     = hs_raw ^ pol[0];
  assign vsync     = vs_raw ^ pol[1];
  assign de        = disp ^ pol[2];
  assign rgb       = !disp ? '0 :
                     !act ? bord :
                     (uf || !pix_gnt) ? ufc : pix_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      for (int i = 1; i < NREG; i++) live[i] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == '0) ctrl_en <= reg_wdata[0];
      else if (int'(reg_addr) < NREG) live[reg_addr] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      uf  <= 1'b0;
      hc  <= '0;
      fc  <= '0;
      for (int i = 1; i < NREG; i++) sh[i] <= '0;
    end else if (!ctrl_en) begin
      run <= 1'b0;
      uf  <= 1'b0;
      hc  <= '0;
      fc  <= '0;
    end else if (!run) begin
      run <= 1'b1;
      uf  <= 1'b0;
      hc  <= '0;
      fc  <= '0;
      for (int i = 1; i < NREG; i++) sh[i] <= live[i];
    end else begin
      if (pix_req && !pix_gnt) uf <= 1'b1;
      if (fwrap) begin
        fc <= '0;
        hc <= '0;
        for (int i = 1; i < NREG; i++) sh[i] <= live[i];
        if (rec) uf <= 1'b0;
      end else begin
        fc <= fc + 1'b1;
        hc <= hwrap ? '0 : hc + 1'b1;
      end
    end
  end

  assert_req_in_display_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> (de ^ pol[2]));
  assert_blank_is_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(de ^ pol[2]) |-> (rgb == '0));
  assert_starved_color_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && !pix_gnt) |-> (rgb == ufc));
  assert_sticky_no_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && run && ctrl_en && !rec) |=> uf);
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && vper > 1) |=> !frame_irq);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pix_req && !frame_irq && rgb == '0));
endmodule

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
  logic        clk = 0, rst_n = 0, reg_wr = 0, pix_gnt = 1;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [23:0] pix_data = 0;
  logic        hsync, vsync, de, pix_req, frame_irq;
  logic [23:0] rgb;

  always #2.5 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_gnt(pix_gnt), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb),
    .pix_req(pix_req), .frame_irq(frame_irq));

  int total = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_live [1:13];
  logic [31:0] m_sh   [1:13];
  bit m_en, m_run, m_uf;
  int m_h, m_f;
  bit e_hs, e_vs, e_de, e_req, e_irq, e_disp;
  logic [23:0] e_rgb;

  task automatic calc();
    int hpw, hds, hde, vpw, vds, vde;
    bit ha, va, act;
    hpw = m_sh[1][15:0];  hde = m_sh[2][31:16]; hds = m_sh[2][15:0];
    vpw = m_sh[4][23:0];  vds = m_sh[5][23:0];  vde = m_sh[6][23:0];
    e_disp = m_run && m_h >= hds && m_h <= hde && m_f >= vds && m_f <= vde;
    ha  = m_sh[7][31] ? (m_h >= int'(m_sh[7][15:0]) && m_h <= int'(m_sh[8][15:0])) : 1;
    va  = m_sh[9][31] ? (m_f >= int'(m_sh[9][23:0]) && m_f <= int'(m_sh[10][23:0])) : 1;
    act = e_disp && ha && va;
    e_req = act && !m_uf;
    e_irq = m_run && m_f == 0;
    e_hs  = (m_run && m_h < hpw) ^ m_sh[11][0];
    e_vs  = (m_run && m_f < vpw) ^ m_sh[11][1];
    e_de  = e_disp ^ m_sh[11][2];
    e_rgb = !e_disp ? 24'h0 : !act ? m_sh[12][23:0] :
            (m_uf || !pix_gnt) ? m_sh[13][23:0] : pix_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_uf = 0; m_h = 0; m_f = 0;
      for (int i = 1; i < 14; i++) begin m_live[i] = 0; m_sh[i] = 0; end
    end else begin
      calc();
      if (!m_en) begin
        m_run = 0; m_uf = 0; m_h = 0; m_f = 0;
      end else if (!m_run) begin
        m_run = 1; m_uf = 0; m_h = 0; m_f = 0;
        for (int i = 1; i < 14; i++) m_sh[i] = m_live[i];
      end else begin
        if (e_req && !pix_gnt) m_uf = 1;
        if (m_f + 1 >= int'(m_sh[3][23:0])) begin
          if (m_sh[13][31]) m_uf = 0;
          m_f = 0; m_h = 0;
          for (int i = 1; i < 14; i++) m_sh[i] = m_live[i];
        end else begin
          m_f++;
          m_h = (m_h + 1 >= int'(m_sh[1][31:16])) ? 0 : m_h + 1;
        end
      end
      if (reg_wr) begin
        if (reg_addr == 0) m_en = reg_wdata[0];
        else if (reg_addr < 14) m_live[reg_addr] = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    calc();
    chk("R2 R9 hsync", hsync, e_hs);
    chk("R3 R9 vsync", vsync, e_vs);
    chk("R4 R9 de", de, e_de);
    chk("R5 R6 R7 pix_req", pix_req, e_req);
    chk("R1 R11 frame_irq", frame_irq, e_irq);
    chk("R5 R6 R7 R8 R10 R12 rgb", rgb, e_rgb);
  end

  always @(posedge clk) begin
    #1 pix_data <= pix_data + 24'h010203;
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a[3:0]; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic starve_once();
    do @(negedge clk); while (!pix_req);
    @(posedge clk); #1 pix_gnt = 0;
    @(posedge clk); #1 pix_gnt = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset hsync", hsync, 1'b0);
    chk("R1 reset de", de, 1'b0);
    chk("R1 reset frame_irq", frame_irq, 1'b0);
    @(posedge clk); #1 rst_n = 1;
    // 14-clock lines, 7-line frame, vertical window skewed by 3 clocks
    wr(1, (32'd14 << 16) | 32'd2);
    wr(2, (32'd11 << 16) | 32'd4);
    wr(3, 98); wr(4, 14); wr(5, 31); wr(6, 86);
    wr(12, 32'h00AA55); wr(13, 32'h0000FF);
    wr(0, 1);
    repeat (200) @(posedge clk);
    #1;
    // R5 R9 R10: inset window, polarity and new border, written mid-frame
    wr(7, 32'h8000_0005); wr(8, 9);
    wr(9, 32'h8000_0000 | 45); wr(10, 72);
    wr(11, 5); wr(12, 32'h123456);
    repeat (300) @(posedge clk);
    #1;
    // R7 R8: starvation with recovery off, sticky until restart
    starve_once();
    repeat (250) @(posedge clk);
    #1 wr(0, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 R9 idle de", de, 1'b1);
    chk("R1 R9 idle hsync", hsync, 1'b1);
    chk("R1 idle pix_req", pix_req, 1'b0);
    @(posedge clk); #1 wr(0, 1);
    repeat (120) @(posedge clk);
    #1;
    // R8: recovery on
    wr(13, 32'h80FF_0000);
    repeat (200) @(posedge clk);
    #1 starve_once();
    repeat (250) @(posedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule